// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Array

This block models a small programmable logic array. It has three programmable parts. The first is an AND plane, where every input can join a product term as itself, inverted, or not at all. The second is an OR plane, where each output collects any subset of the product terms. The third is a per-output inversion stage. Because one product term can feed several outputs, a set of logic functions can share common terms.

A loader fills the internal fuse registers through a plain write port, one fuse row per write. Each write lands on a rising clock edge. Once the rows are loaded, the outputs follow the live inputs with no clock in the path. While the loader holds the busy pin high, every output is held at 0. The data path has no flow control. Inputs and outputs are levels, so no back-pressure exists. The loader must keep the busy pin high until its last row has been written.

The number of inputs, product terms and outputs are parameters. The defaults are 3, 4 and 2.

Top module: `pla_core`

## Requirements
- R1: After reset every fuse row is clear, so every output is 0 for every input pattern.
- R2: A write with `cfg_we` high is stored on the rising clock edge, and the outputs reflect it only after that edge. Before that edge the outputs keep their old values.
- R3: Address t (0 to N_TERM-1) holds the AND row of product term t. Input i is controlled by bits [2i+1:2i] of that row: 00 leaves the input out, 01 uses the input as is, and 10 uses its complement.
- R4: The literal code 11 is reserved, and any product term that contains it evaluates to 0.
- R5: A product term whose literal codes are all 00 evaluates to 0.
- R6: Address N_TERM+o holds the OR row of output o. Bits [N_TERM-1:0] select the product terms, and the output's sum is the OR of the selected terms.
- R7: Bit N_TERM of an OR row is the polarity fuse: 0 passes the sum unchanged, and 1 inverts it.
- R8: A single product term may be selected by several outputs at once and drives each of them.
- R9: While `cfg_busy` is high, every output is 0 whatever the fuses and inputs are.
- R10: A write to an address at or above N_TERM+N_OUT changes no fuse row.
- R11: With A=in[2], B=in[1] and C=in[0], the array can be loaded so that out[0] = AB' + AC + A'BC' and out[1] = (AC + BC)'. In this configuration term AC is shared by both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for fuse writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears all fuses |
| cfg_we | input | 1 | Write strobe for one fuse row |
| cfg_addr | input | $clog2(N_TERM+N_OUT) | Fuse row address: AND rows first, then OR rows |
| cfg_data | input | max(2*N_IN, N_TERM+1) | Row contents |
| cfg_busy | input | 1 | Held high by the loader during configuration; blanks the outputs |
| pla_in | input | N_IN | Live logic inputs |
| pla_out | output | N_OUT | Combinational outputs |

## Verification
The bench goes after the AND-row corners. A term with no literals must read 0: a design that read it as 1 would drive its outputs high. The reserved code 11 must kill its term: a design that treated it as a don't-care would leave the term alive. It checks that a write appears only after the clock edge. A design with a transparent write path would change the outputs before the edge. It loads the shared-term functions and checks all eight input patterns, then flips a polarity fuse. This catches a swapped literal position or an inversion applied to the wrong output. It writes garbage to unmapped addresses, which would corrupt a row if the address decode wrapped. It also raises busy with the inverted output configured, which exposes gating placed before the polarity stage.

// File: rtl/pla_cfg_pkg.sv
package pla_cfg_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_BAD  = 2'b11
  } lit_e;
endpackage

// File: rtl/pla_fuse_bank.sv
module pla_fuse_bank #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int DW     = 6,
  parameter int AW     = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [AW-1:0]                      cfg_addr,
  input  logic [DW-1:0]                      cfg_data,
  output logic [N_TERM-1:0][2*N_IN-1:0]      and_fuse,
  output logic [N_OUT-1:0][N_TERM-1:0]       or_fuse,
  output logic [N_OUT-1:0]                   pol_fuse
);
  localparam int ROWS = N_TERM + N_OUT;
  localparam int LW   = 2 * N_IN;

  // AND rows at addresses 0..N_TERM-1
  for (genvar t = 0; t < N_TERM; t++) begin : g_and_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        and_fuse[t] <= '0;
      else if (cfg_we && cfg_addr == AW'(t))
        and_fuse[t] <= cfg_data[LW-1:0];
    end

    // R2: a write to an AND row is visible after the edge
    p_and_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(t)) |=> and_fuse[t] == $past(cfg_data[LW-1:0]));
  end

  // OR rows plus polarity fuse at addresses N_TERM..ROWS-1
  for (genvar o = 0; o < N_OUT; o++) begin : g_or_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        or_fuse[o]  <= '0;
        pol_fuse[o] <= 1'b0;
      end else if (cfg_we && cfg_addr == AW'(N_TERM + o)) begin
        or_fuse[o]  <= cfg_data[N_TERM-1:0];
        pol_fuse[o] <= cfg_data[N_TERM];
      end
    end
  end

  // R10: writes outside the map leave every row untouched
  p_unmapped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && 32'(cfg_addr) >= ROWS) |=>
      ($stable(and_fuse) && $stable(or_fuse) && $stable(pol_fuse)));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_cfg_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_TERM-1:0][2*N_IN-1:0] and_fuse,
  input  logic [N_IN-1:0]               pla_in,
  output logic [N_TERM-1:0]             term
);
  logic [N_TERM-1:0][N_IN-1:0] lit_pass;
  logic [N_TERM-1:0][N_IN-1:0] lit_used;
  logic [N_TERM-1:0][N_IN-1:0] lit_bad;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      lit_e code;
      assign code = lit_e'(and_fuse[t][2*i +: 2]);

      always_comb begin
        lit_used[t][i] = 1'b1;
        lit_bad[t][i]  = 1'b0;
        case (code)
          LIT_OFF:  begin lit_pass[t][i] = 1'b1; lit_used[t][i] = 1'b0; end
          LIT_TRUE: lit_pass[t][i] = pla_in[i];
          LIT_COMP: lit_pass[t][i] = ~pla_in[i];
          default:  begin lit_pass[t][i] = 1'b0; lit_bad[t][i] = 1'b1; end
        endcase
      end

      // R3: a true literal blocks the term when its input is low
      p_true_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (and_fuse[t][2*i +: 2] == 2'b01 && !pla_in[i]) |-> !term[t]);
      // R3: a complemented literal blocks the term when its input is high
      p_comp_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (and_fuse[t][2*i +: 2] == 2'b10 && pla_in[i]) |-> !term[t]);
    end

    // an empty row must not produce a constant-1 term
    assign term[t] = (&lit_pass[t]) & (|lit_used[t]);

    p_reserved_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|lit_bad[t]) |-> !term[t]);
    p_empty_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (and_fuse[t] == '0) |-> !term[t]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_TERM-1:0]           term,
  input  logic [N_OUT-1:0][N_TERM-1:0] or_fuse,
  input  logic [N_OUT-1:0]            pol_fuse,
  input  logic                        cfg_busy,
  output logic [N_OUT-1:0]            pla_out
);
  logic [N_OUT-1:0] sop;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sop[o]     = |(term & or_fuse[o]);
    assign pla_out[o] = cfg_busy ? 1'b0 : (sop[o] ^ pol_fuse[o]);

    for (genvar t = 0; t < N_TERM; t++) begin : g_chk
      // R6/R8: any live selected term sets the sum, whichever output shares it
      p_term_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (term[t] && or_fuse[o][t] && !cfg_busy) |-> (pla_out[o] != pol_fuse[o]));
    end

    // R7: with no live term the output equals its polarity fuse
    p_polarity_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_busy && (term & or_fuse[o]) == '0) |-> (pla_out[o] == pol_fuse[o]));
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int ROWS  = N_TERM + N_OUT,
  localparam int AW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int DW    = (2 * N_IN > N_TERM + 1) ? 2 * N_IN : N_TERM + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_data,
  input  logic              cfg_busy,
  input  logic [N_IN-1:0]   pla_in,
  output logic [N_OUT-1:0]  pla_out
);
  logic [N_TERM-1:0][2*N_IN-1:0] and_fuse;
  logic [N_OUT-1:0][N_TERM-1:0]  or_fuse;
  logic [N_OUT-1:0]              pol_fuse;
  logic [N_TERM-1:0]             term;

  pla_fuse_bank #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .DW(DW), .AW(AW)
  ) u_fuses (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .and_fuse(and_fuse), .or_fuse(or_fuse),
    .pol_fuse(pol_fuse)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst_n(rst_n), .and_fuse(and_fuse), .pla_in(pla_in),
    .term(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst_n(rst_n), .term(term), .or_fuse(or_fuse),
    .pol_fuse(pol_fuse), .cfg_busy(cfg_busy), .pla_out(pla_out)
  );

  // R9: busy blanks every output
  p_busy_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |-> (pla_out == '0));
endmodule

// File: tb/pla_core_tb.sv
module pla_core_tb;
  localparam int NI = 3;
  localparam int NT = 4;
  localparam int NO = 2;
  localparam int AW = 3;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          cfg_busy = 1'b0;
  logic [NI-1:0] pla_in = '0;
  logic [NO-1:0] pla_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pla_core #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_busy(cfg_busy), .pla_in(pla_in),
    .pla_out(pla_out)
  );

  // reference equations, A=in[2], B=in[1], C=in[0]
  function automatic logic [1:0] ref_f(logic [2:0] v);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    ref_f[0] = (a & ~b) | (a & c) | (~a & b & ~c);
    ref_f[1] = ~((a & c) | (b & c));
  endfunction

  task automatic check(string req, logic [NO-1:0] got, logic [NO-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%b expected=%b in=%b", req, got, exp, pla_in);
    end
  endtask

  task automatic write_row(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_in(logic [NI-1:0] v);
    pla_in = v;
    #1;
  endtask

  task automatic load_f();
    write_row(3'd0, 6'b011000); // A, B'
    write_row(3'd1, 6'b010001); // A, C
    write_row(3'd2, 6'b100110); // A', B, C'
    write_row(3'd3, 6'b000101); // B, C
    write_row(3'd4, 6'b000111); // out0: terms 0,1,2, true
    write_row(3'd5, 6'b011010); // out1: terms 1,3, inverted
  endtask

  task automatic clear_all();
    for (int r = 0; r < NT + NO; r++) write_row(AW'(r), '0);
  endtask

  task automatic t_reset();
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R1 reset clear", pla_out, 2'b00);
    end
  endtask

  task automatic t_empty_term();
    write_row(3'd4, 6'b000001); // out0 selects empty term 0, true
    for (int v = 0; v < 8; v += 3) begin
      set_in(3'(v));
      check("R5 empty term", pla_out, 2'b00);
    end
    write_row(3'd4, 6'b010001); // invert: empty term must read as 0
    set_in(3'b101);
    check("R5 empty term inverted", pla_out, 2'b01);
    write_row(3'd4, 6'b000001);
  endtask

  task automatic t_literals();
    write_row(3'd0, 6'b000001); // in0 true
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R3 true literal", pla_out, {1'b0, v[0]});
    end
    write_row(3'd0, 6'b000010); // in0 complement
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R3 complement literal", pla_out, {1'b0, ~v[0]});
    end
    write_row(3'd0, 6'b010000); // in2 true
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R3 literal position", pla_out, {1'b0, v[2]});
    end
  endtask

  task automatic t_reserved();
    write_row(3'd0, 6'b000011);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R4 reserved code", pla_out, 2'b00);
    end
    write_row(3'd0, 6'b110101);
    set_in(3'b011);
    check("R4 reserved code high input", pla_out, 2'b00);
  endtask

  task automatic t_write_timing();
    write_row(3'd0, 6'b000001);
    set_in(3'b001);
    check("R2 before write", pla_out, 2'b01);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_data = 6'b000010;
    #1;
    check("R2 not before edge", pla_out, 2'b01);
    @(posedge clk); #1;
    check("R2 after edge", pla_out, 2'b00);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_functions(string req);
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check(req, pla_out, ref_f(3'(v)));
    end
  endtask

  task automatic t_sharing();
    set_in(3'b101); // AC live: out0 high, out1 low
    check("R8 shared term", pla_out, 2'b01);
    set_in(3'b111);
    check("R8 shared term ABC", pla_out, 2'b01);
    set_in(3'b000);
    check("R6 no term selected live", pla_out, 2'b10);
  endtask

  task automatic t_polarity();
    write_row(3'd4, 6'b010111); // invert out0
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R7 polarity flip", pla_out, ref_f(3'(v)) ^ 2'b01);
    end
    write_row(3'd4, 6'b000111);
  endtask

  task automatic t_unmapped();
    write_row(3'd6, 6'b111111);
    write_row(3'd7, 6'b101010);
    t_functions("R10 unmapped write ignored");
  endtask

  task automatic t_busy();
    cfg_busy = 1'b1;
    for (int v = 0; v < 8; v++) begin
      set_in(3'(v));
      check("R9 busy blank", pla_out, 2'b00);
    end
    cfg_busy = 1'b0;
    set_in(3'b000);
    check("R9 busy release", pla_out, ref_f(3'b000));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty_term();
    t_literals();
    t_reserved();
    t_write_timing();
    clear_all();
    load_f();
    t_functions("R11 shared-term functions");
    t_sharing();
    t_polarity();
    t_unmapped();
    t_busy();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1-R11 run: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule